// File: doc/BRIEF.md
# Palette RAM Write Sequencer

This block holds a colour lookup table of 256 RGB entries with 8 bits per component. It is loaded over a 32-bit register port with four word registers: entry address, colour data, indirect control and overlay map. The colour data register is a stream of 8-bit components in red, green, blue order. The block assembles each triple and commits it to the addressed entry. The entry address then moves on by itself, so software sets the address once and streams data after it.

A packing-mode pin sets how much each data write carries. In packed mode one word carries four components, most significant byte first, so an entry boundary can fall inside a word. In single mode each word carries one component in its top byte. Writes to the control register reach an internal register chosen by the current entry address: a read mask or a command byte.

The pixel lookup port ANDs an 8-bit pixel index with the read mask and returns the selected entry's RGB one clock later. A mask of zero maps every pixel to entry 0, which blanks the screen.

Top module: `pal_ram_seq`

## Requirements
- R1: Components of an entry arrive as red, then green, then blue. The entry keeps its old value until blue arrives, and all three components are then written together in one cycle.
- R2: After each completed entry the entry address increases by one, wrapping from 255 to 0, so consecutive data writes fill consecutive entries.
- R3: With `pack_mode`=1 a data write supplies four components from bits 31:24, 23:16, 15:8 and 7:0 in that order. One word may finish one entry and start the next, and may complete two entries.
- R4: With `pack_mode`=0 a data write supplies exactly one component, taken from bits 31:24. Bits 23:0 are ignored.
- R5: An address write loads the entry address and restarts the sequence at red, discarding any partly received components. The address byte is taken from bits 7:0 when `pack_mode`=1 and from bits 31:24 when `pack_mode`=0.
- R6: A control write stores its byte, taken from the same position as in R5, into the read mask when the entry address is 0x04 and into the command register when it is 0x06. Control writes to any other index are dropped. A control write never changes the entry address or the component sequence.
- R7: `pix_rgb` presents {red[23:16], green[15:8], blue[7:0]} of entry (`pix_idx` AND read mask), registered one clock after `pix_idx` is applied.
- R8: After reset the entry address is 0, the sequence expects red, the read mask is 0xFF, the command register is 0x00 and every table entry is 0.
- R9: Overlay-map writes (`bus_sel`=3) and cycles with `bus_wr`=0 leave the table, the entry address and the component sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_sel | input | 2 | Register select: 0 address, 1 colour data, 2 control, 3 overlay map |
| bus_wdata | input | 32 | Write data word |
| pack_mode | input | 1 | 1: four components per data word; 0: one component in the top byte |
| pix_idx | input | 8 | Pixel index for lookup |
| pix_rgb | output | 24 | Looked-up colour, one cycle after the index |
| read_mask | output | 8 | Current read mask |
| cmd_reg | output | 8 | Current command register |
| entry_addr | output | 8 | Current entry address |

## Verification
The bench builds the block with its default parameters: a 32-bit bus and 8-bit components, giving four lanes per word and two commit ports. With these values a packed stream reaches the case where one word completes two entries, and the case where an entry boundary falls after the first or the third byte. The 256-entry table is small enough for a single-mode write sequence to carry the address from 255 back to 0. A reference table fed from the same component stream gives the expected value of every lookup. Lookups run under full, partial and zero read masks.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_OVL  = 2'd3
    } bus_sel_e;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } comp_phase_e;

endpackage

// File: rtl/pal_unpack.sv
// Splits one bus word into component lanes, lane 0 being the top byte.
module pal_unpack #(
    parameter int BUS_W  = 32,
    parameter int COMP_W = 8,
    localparam int LANES = BUS_W / COMP_W
) (
    input  logic [BUS_W-1:0]              wdata,
    input  logic                          pack_mode,
    input  logic                          data_wr,
    output logic [LANES-1:0][COMP_W-1:0]  lane_comp,
    output logic [LANES-1:0]              lane_vld,
    output logic [COMP_W-1:0]             reg_byte
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_comp[i] = wdata[BUS_W-1-i*COMP_W -: COMP_W];
        if (i == 0) begin : g_first
            assign lane_vld[i] = data_wr;
        end else begin : g_rest
            assign lane_vld[i] = data_wr && pack_mode;
        end
    end

    // Register bytes sit in the low byte when packed, top byte otherwise.
    assign reg_byte = pack_mode ? wdata[COMP_W-1:0] : wdata[BUS_W-1 -: COMP_W];

endmodule

// File: rtl/pal_sequencer.sv
// Assembles R,G,B triples from the component lanes and issues table commits.
module pal_sequencer #(
    parameter int LANES   = 4,
    parameter int COMP_W  = 8,
    parameter int AW      = 8,
    localparam int NCOMMIT = (LANES + 2) / 3,
    localparam int SW      = (NCOMMIT > 1) ? $clog2(NCOMMIT) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            addr_wr,
    input  logic [AW-1:0]                   addr_val,
    input  logic [LANES-1:0][COMP_W-1:0]    lane_comp,
    input  logic [LANES-1:0]                lane_vld,
    output logic [AW-1:0]                   cur_addr,
    output logic [1:0]                      cur_phase,
    output logic [NCOMMIT-1:0]              wr_en,
    output logic [NCOMMIT-1:0][AW-1:0]      wr_addr,
    output logic [NCOMMIT-1:0][3*COMP_W-1:0] wr_rgb
);
    import pal_pkg::*;

    typedef struct packed {
        logic [AW-1:0]     addr;
        comp_phase_e       phase;
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] grn;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [SW-1:0] slot;

    always_comb begin
        st_d    = st_q;
        wr_en   = '0;
        wr_addr = '0;
        wr_rgb  = '0;
        slot    = '0;
        if (addr_wr) begin
            st_d.addr  = addr_val;
            st_d.phase = PH_RED;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_vld[i]) begin
                    case (st_d.phase)
                        PH_RED: begin
                            st_d.red   = lane_comp[i];
                            st_d.phase = PH_GREEN;
                        end
                        PH_GREEN: begin
                            st_d.grn   = lane_comp[i];
                            st_d.phase = PH_BLUE;
                        end
                        default: begin
                            wr_en[slot]   = 1'b1;
                            wr_addr[slot] = st_d.addr;
                            wr_rgb[slot]  = {st_d.red, st_d.grn, lane_comp[i]};
                            st_d.addr     = st_d.addr + AW'(1);
                            st_d.phase    = PH_RED;
                            slot          = slot + SW'(1);
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{addr: '0, phase: PH_RED, red: '0, grn: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_addr  = st_q.addr;
    assign cur_phase = st_q.phase;

endmodule

// File: rtl/pal_ctrl_regs.sv
// Indirect control registers selected by the entry address.
module pal_ctrl_regs #(
    parameter int AW       = 8,
    parameter int COMP_W   = 8,
    parameter logic [AW-1:0] MASK_IDX = 8'h04,
    parameter logic [AW-1:0] CMD_IDX  = 8'h06,
    parameter logic [COMP_W-1:0] CMD_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [AW-1:0]     sel_idx,
    input  logic [COMP_W-1:0] ctrl_val,
    output logic [AW-1:0]     read_mask,
    output logic [COMP_W-1:0] cmd
);

    typedef struct packed {
        logic [AW-1:0]     mask;
        logic [COMP_W-1:0] cmd;
    } ctrl_state_t;

    ctrl_state_t cr_d, cr_q;

    always_comb begin
        cr_d = cr_q;
        if (ctrl_wr) begin
            if (sel_idx == MASK_IDX) begin
                cr_d.mask = ctrl_val[AW-1:0];
            end else if (sel_idx == CMD_IDX) begin
                cr_d.cmd = ctrl_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q <= '{mask: '1, cmd: CMD_RST};
        end else begin
            cr_q <= cr_d;
        end
    end

    assign read_mask = cr_q.mask;
    assign cmd       = cr_q.cmd;

endmodule

// File: rtl/pal_table.sv
// RGB storage with several commit ports and a registered masked lookup.
module pal_table #(
    parameter int AW      = 8,
    parameter int COMP_W  = 8,
    parameter int NCOMMIT = 2,
    localparam int ENTRIES = 2 ** AW,
    localparam int RGB_W   = 3 * COMP_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCOMMIT-1:0]           wr_en,
    input  logic [NCOMMIT-1:0][AW-1:0]   wr_addr,
    input  logic [NCOMMIT-1:0][RGB_W-1:0] wr_rgb,
    input  logic [AW-1:0]                look_idx,
    input  logic [AW-1:0]                look_mask,
    output logic [RGB_W-1:0]             look_rgb
);

    logic [RGB_W-1:0] mem_d [ENTRIES];
    logic [RGB_W-1:0] mem_q [ENTRIES];
    logic [RGB_W-1:0] rgb_d, rgb_q;

    always_comb begin
        mem_d = mem_q;
        for (int s = 0; s < NCOMMIT; s++) begin
            if (wr_en[s]) begin
                mem_d[wr_addr[s]] = wr_rgb[s];
            end
        end
        rgb_d = mem_q[look_idx & look_mask];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
            rgb_q <= '0;
        end else begin
            mem_q <= mem_d;
            rgb_q <= rgb_d;
        end
    end

    assign look_rgb = rgb_q;

endmodule

// File: rtl/pal_ram_seq.sv
module pal_ram_seq #(
    parameter int BUS_W  = 32,
    parameter int COMP_W = 8,
    localparam int AW      = COMP_W,
    localparam int LANES   = BUS_W / COMP_W,
    localparam int NCOMMIT = (LANES + 2) / 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_sel,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              pack_mode,
    input  logic [AW-1:0]     pix_idx,
    output logic [3*COMP_W-1:0] pix_rgb,
    output logic [AW-1:0]     read_mask,
    output logic [COMP_W-1:0] cmd_reg,
    output logic [AW-1:0]     entry_addr
);
    import pal_pkg::*;

    logic                            data_wr, addr_wr, ctrl_wr;
    logic [LANES-1:0][COMP_W-1:0]    lane_comp;
    logic [LANES-1:0]                lane_vld;
    logic [COMP_W-1:0]               reg_byte;
    logic [AW-1:0]                   seq_addr;
    logic [1:0]                      seq_phase;
    logic [NCOMMIT-1:0]              wr_en;
    logic [NCOMMIT-1:0][AW-1:0]      wr_addr;
    logic [NCOMMIT-1:0][3*COMP_W-1:0] wr_rgb;

    assign data_wr = bus_wr && (bus_sel == SEL_DATA);
    assign addr_wr = bus_wr && (bus_sel == SEL_ADDR);
    assign ctrl_wr = bus_wr && (bus_sel == SEL_CTRL);

    pal_unpack #(.BUS_W(BUS_W), .COMP_W(COMP_W)) unpack_i (
        .wdata     (bus_wdata),
        .pack_mode (pack_mode),
        .data_wr   (data_wr),
        .lane_comp (lane_comp),
        .lane_vld  (lane_vld),
        .reg_byte  (reg_byte)
    );

    pal_sequencer #(.LANES(LANES), .COMP_W(COMP_W), .AW(AW)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_wr   (addr_wr),
        .addr_val  (reg_byte),
        .lane_comp (lane_comp),
        .lane_vld  (lane_vld),
        .cur_addr  (seq_addr),
        .cur_phase (seq_phase),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_rgb    (wr_rgb)
    );

    pal_ctrl_regs #(.AW(AW), .COMP_W(COMP_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .sel_idx   (seq_addr),
        .ctrl_val  (reg_byte),
        .read_mask (read_mask),
        .cmd       (cmd_reg)
    );

    pal_table #(.AW(AW), .COMP_W(COMP_W), .NCOMMIT(NCOMMIT)) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_rgb    (wr_rgb),
        .look_idx  (pix_idx),
        .look_mask (read_mask),
        .look_rgb  (pix_rgb)
    );

    assign entry_addr = seq_addr;

endmodule

// File: rtl/pal_ram_seq_chk.sv
module pal_ram_seq_chk #(
    parameter int AW = 8,
    parameter int NC = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [1:0]    bus_sel,
    input logic          pack_mode,
    input logic          data_wr,
    input logic          addr_wr,
    input logic [AW-1:0] reg_byte,
    input logic [AW-1:0] seq_addr,
    input logic [1:0]    seq_phase,
    input logic [NC-1:0] wr_en
);

    // R1: the sequence phase only takes red, green or blue
    a_r1_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
        seq_phase != 2'd3);

    // R1: a table commit only happens on a colour data write
    a_r1_commit_on_data: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en != '0) |-> data_wr);

    // R2: the address advances by the number of entries completed
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> seq_addr == $past(seq_addr) + AW'($countones($past(wr_en))));

    // R4: single mode completes at most one entry per write
    a_r4_single_one: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !pack_mode) |-> $countones(wr_en) <= 1);

    // R5: an address write loads the address and restarts at red
    a_r5_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> (seq_addr == $past(reg_byte)) && (seq_phase == 2'd0));

    // R6: control writes leave address and sequence alone
    a_r6_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd2) |=> $stable(seq_addr) && $stable(seq_phase));

    // R9: idle cycles and overlay writes leave address and sequence alone
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || bus_sel == 2'd3) |=> $stable(seq_addr) && $stable(seq_phase));

    // R9: no commit without a colour data write
    a_r9_no_commit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || bus_sel == 2'd3) |-> wr_en == '0);

endmodule

bind pal_ram_seq pal_ram_seq_chk #(.AW(AW), .NC(NCOMMIT)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_sel   (bus_sel),
    .pack_mode (pack_mode),
    .data_wr   (data_wr),
    .addr_wr   (addr_wr),
    .reg_byte  (reg_byte),
    .seq_addr  (seq_addr),
    .seq_phase (seq_phase),
    .wr_en     (wr_en)
);

// File: tb/pal_ram_seq_tb_top.sv
`timescale 1ns/1ps
module pal_ram_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic        pack_mode = 1'b1;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;
    logic [7:0]  read_mask, cmd_reg, entry_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    logic [23:0] ref_tab [256];
    logic [7:0]  ref_addr, ref_mask, ref_cmd, ref_r, ref_g;
    int          ref_ph;

    always #5 clk = ~clk;

    pal_ram_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .pack_mode(pack_mode), .pix_idx(pix_idx),
        .pix_rgb(pix_rgb), .read_mask(read_mask), .cmd_reg(cmd_reg),
        .entry_addr(entry_addr)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic ref_push(input logic [7:0] c);
        if (ref_ph == 0) begin ref_r = c; ref_ph = 1; end
        else if (ref_ph == 1) begin ref_g = c; ref_ph = 2; end
        else begin
            ref_tab[ref_addr] = {ref_r, ref_g, c};
            ref_addr = ref_addr + 8'd1;
            ref_ph = 0;
        end
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [31:0] d);
        logic [7:0] rb;
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        rb = pack_mode ? d[7:0] : d[31:24];
        case (sel)
            2'd0: begin ref_addr = rb; ref_ph = 0; end
            2'd1: begin
                if (pack_mode) begin
                    for (int k = 0; k < 4; k++) ref_push(d[31-8*k -: 8]);
                end else begin
                    ref_push(d[31:24]);
                end
            end
            2'd2: begin
                if (ref_addr == 8'h04) ref_mask = rb;
                else if (ref_addr == 8'h06) ref_cmd = rb;
            end
            default: ;
        endcase
    endtask

    task automatic look(input string req, input logic [7:0] idx);
        @(negedge clk);
        pix_idx = idx;
        @(negedge clk);
        check(req, {8'h0, pix_rgb}, {8'h0, ref_tab[idx & ref_mask]});
    endtask

    task automatic t_reset;
        check("R8 addr", {24'h0, entry_addr}, 32'h0);
        check("R8 mask", {24'h0, read_mask}, 32'hFF);
        check("R8 cmd", {24'h0, cmd_reg}, 32'h0);
        look("R8 entry0", 8'h00);
        look("R8 entry200", 8'd200);
    endtask

    task automatic t_packed;
        pack_mode = 1'b1;
        bus_write(2'd0, 32'h0000_0000);
        bus_write(2'd1, 32'h1122_3344);
        check("R3 R2 addr after first word", {24'h0, entry_addr}, 32'd1);
        look("R3 entry0 complete", 8'd0);
        look("R1 entry1 still old", 8'd1);
        check("R1 entry1 old value", {8'h0, ref_tab[1]}, 32'h0);
        bus_write(2'd1, 32'h5566_7788);
        bus_write(2'd1, 32'h99AA_BBCC);
        check("R3 two entries in one word", {24'h0, entry_addr}, 32'd4);
        bus_write(2'd1, 32'hDDEE_F001);
        bus_write(2'd1, 32'h0203_0405);
        bus_write(2'd1, 32'h0607_0809);
        check("R2 addr after six words", {24'h0, entry_addr}, 32'd8);
        for (int e = 0; e < 8; e++) look("R3 packed entry", 8'(e));
    endtask

    task automatic t_single;
        pack_mode = 1'b0;
        bus_write(2'd0, 32'h40AB_CDEF);
        check("R5 single addr byte", {24'h0, entry_addr}, 32'h40);
        bus_write(2'd1, 32'hA1FF_FFFF);
        bus_write(2'd1, 32'hB2FF_FFFF);
        bus_write(2'd1, 32'hC3FF_FFFF);
        bus_write(2'd1, 32'hD400_0000);
        bus_write(2'd1, 32'hE512_3456);
        bus_write(2'd1, 32'hF678_9ABC);
        check("R4 one comp per write", {24'h0, entry_addr}, 32'h42);
        look("R4 entry 0x40", 8'h40);
        look("R4 entry 0x41", 8'h41);
    endtask

    task automatic t_partial;
        pack_mode = 1'b0;
        bus_write(2'd0, 32'h0A00_0000);
        bus_write(2'd1, 32'h7700_0000);
        bus_write(2'd1, 32'h8800_0000);
        look("R1 partial keeps old", 8'd10);
        check("R1 addr holds mid entry", {24'h0, entry_addr}, 32'd10);
        bus_write(2'd1, 32'h9900_0000);
        look("R1 commit on blue", 8'd10);
    endtask

    task automatic t_restart;
        pack_mode = 1'b0;
        bus_write(2'd0, 32'h1400_0000);
        bus_write(2'd1, 32'h1100_0000);
        bus_write(2'd1, 32'h2200_0000);
        bus_write(2'd0, 32'h1500_0000);
        bus_write(2'd1, 32'h3300_0000);
        bus_write(2'd1, 32'h4400_0000);
        bus_write(2'd1, 32'h5500_0000);
        look("R5 dropped partial entry", 8'd20);
        look("R5 restart at red", 8'd21);
    endtask

    task automatic t_wrap;
        pack_mode = 1'b0;
        bus_write(2'd0, 32'hFF00_0000);
        bus_write(2'd1, 32'h0100_0000);
        bus_write(2'd1, 32'h0200_0000);
        bus_write(2'd1, 32'h0300_0000);
        check("R2 wrap to 0", {24'h0, entry_addr}, 32'd0);
        look("R2 entry 255", 8'hFF);
        pack_mode = 1'b1;
        bus_write(2'd0, 32'h0000_00FE);
        bus_write(2'd1, 32'hA0A1_A2B0);
        bus_write(2'd1, 32'hB1B2_C0C1);
        check("R2 R3 packed wrap addr", {24'h0, entry_addr}, 32'd0);
        look("R2 packed entry 254", 8'hFE);
        look("R2 packed entry 255", 8'hFF);
    endtask

    task automatic t_ctrl;
        pack_mode = 1'b1;
        bus_write(2'd0, 32'h0000_0004);
        bus_write(2'd2, 32'hFFFF_FF0F);
        check("R6 mask write", {24'h0, read_mask}, 32'h0F);
        check("R6 addr unchanged", {24'h0, entry_addr}, 32'h04);
        look("R7 partial mask", 8'h41);
        bus_write(2'd0, 32'h0000_0006);
        bus_write(2'd2, 32'h0000_0073);
        check("R6 cmd write", {24'h0, cmd_reg}, 32'h73);
        bus_write(2'd0, 32'h0000_0005);
        bus_write(2'd2, 32'h0000_00AA);
        check("R6 other index mask", {24'h0, read_mask}, 32'h0F);
        check("R6 other index cmd", {24'h0, cmd_reg}, 32'h73);
        pack_mode = 1'b0;
        bus_write(2'd0, 32'h0400_0000);
        bus_write(2'd2, 32'h0011_2233);
        check("R6 single mode mask byte", {24'h0, read_mask}, 32'h00);
        look("R7 zero mask blanks", 8'hC3);
        look("R7 zero mask blanks 2", 8'h07);
        bus_write(2'd2, 32'hFF00_0000);
        check("R6 mask restored", {24'h0, read_mask}, 32'hFF);
        look("R7 full mask", 8'h41);
    endtask

    task automatic t_overlay;
        pack_mode = 1'b0;
        bus_write(2'd0, 32'h1E00_0000);
        bus_write(2'd1, 32'h6100_0000);
        bus_write(2'd1, 32'h6200_0000);
        bus_write(2'd3, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        check("R9 overlay keeps addr", {24'h0, entry_addr}, 32'h1E);
        look("R9 overlay no commit", 8'h1E);
        bus_write(2'd1, 32'h6300_0000);
        look("R9 sequence survived", 8'h1E);
        check("R9 addr after blue", {24'h0, entry_addr}, 32'h1F);
    endtask

    initial begin
        for (int e = 0; e < 256; e++) ref_tab[e] = '0;
        ref_addr = '0; ref_mask = 8'hFF; ref_cmd = '0; ref_r = '0; ref_g = '0; ref_ph = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_packed;
        t_single;
        t_partial;
        t_restart;
        t_wrap;
        t_ctrl;
        t_overlay;
        check("R6 final cmd", {24'h0, cmd_reg}, {24'h0, ref_cmd});
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule